// File: doc/BRIEF.md
# Serial EEPROM configuration autoloader

This block fills a set of device configuration registers from a 1 Kbit serial EEPROM that uses the Microwire protocol. The EEPROM is organised as 16-bit words. Byte address 2n is the low byte of word n and byte address 2n+1 is its high byte. A load pass reads words 0 through 24 in ascending order, one read frame per word. Word 0 is a signature, and it must equal 8129h. If it does not, the pass ends at once, an error flag is raised and no register changes. If the signature matches, each later word is written into the register fields it carries as soon as it arrives.

A pass starts by itself after the asynchronous reset is released. A new pass starts whenever the load request is pulsed while the block is idle. The serial clock comes from the system clock through a parameterised divider and runs freely. Chip select frames each word.

Vendor and device identifiers are fixed values and are never taken from the EEPROM. One EEPROM bit, the flow-control disable bit, is stored inverted as the pause-advertisement bit.

Top module: `eeprom_autoload`

## Requirements
- R1: After reset is released, a pass starts without any request. `busy_o` is high while the pass runs. At the end, `done_o` is high for exactly one clock, and `busy_o` is already low in that clock.
- R2: Each word read is one frame. `ee_cs_o` goes high, and `ee_di_o` carries a start bit 1, then opcode bits 1 and 0, then the 6-bit word address, all MSB first. The EEPROM then returns a dummy bit followed by 16 data bits, MSB first, on `ee_do_i`. `ee_di_o` changes only as `ee_sk_o` falls. `ee_do_i` is sampled as `ee_sk_o` rises. `ee_cs_o` is low between frames and whenever the block is idle.
- R3: A pass with a good signature reads word addresses 0 to 24, each exactly once, in ascending order.
- R4: If word 0 is not 8129h, no further word is read and `sig_err_o` is set. No configuration output changes in that pass. `sig_err_o` is cleared when the next pass starts.
- R5: `ven_id_o` is always 10ECh and `dev_id_o` is always 8139h.
- R6: `sub_ven_o` is loaded from word 3 and `sub_id_o` from word 4. Each takes the full word, with the low byte at the lower address.
- R7: `min_gnt_o` is loaded from the low byte of word 5 and `max_lat_o` from its high byte.
- R8: Let b be the low byte of word 6. `media_o[7:6]` takes b[7:6]. `bmcr_o` bits 13, 12 and 8 take b[5], b[4] and b[0]. All other bits of `media_o` and `bmcr_o` are 0. b[3:2] have no effect.
- R9: `anar_pause_o` takes the inverse of b[1]. Its reset value is 1, which means pause is advertised.
- R10: `cfg3_o` takes the high byte of word 6. `mac_o` takes words 7 to 9, with the byte at the lowest address in `mac_o[7:0]`. `cfg0_o` and `cfg1_o` take the low and high bytes of word 10. `pm_cap_o` takes word 11. `pm_csr_o` and `cfg4_o` take the low and high bytes of word 12.
- R11: A pulse on `load_req_i` while the block is idle starts a new pass. A pulse while `busy_o` is high is ignored.
- R12: Words 1, 2 and 13 to 24 are read but change no output.
- R13: While reset is held, every configuration output is 0 except `anar_pause_o`, and `busy_o`, `done_o`, `sig_err_o` and `ee_cs_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Software request for a new load pass |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-clock pulse at the end of a pass |
| sig_err_o | output | 1 | Signature mismatch in the last pass |
| ven_id_o | output | 16 | Fixed vendor identifier |
| dev_id_o | output | 16 | Fixed device identifier |
| sub_ven_o | output | 16 | Subsystem vendor identifier |
| sub_id_o | output | 16 | Subsystem identifier |
| min_gnt_o | output | 8 | Minimum grant timer byte |
| max_lat_o | output | 8 | Maximum latency timer byte |
| media_o | output | 8 | Media status bits (7:6 loaded) |
| bmcr_o | output | 16 | Basic mode control bits (13, 12, 8 loaded) |
| anar_pause_o | output | 1 | Pause advertisement bit |
| cfg3_o | output | 8 | Configuration byte 3 |
| mac_o | output | 48 | Station address, first byte in bits 7:0 |
| cfg0_o | output | 8 | Configuration byte 0 |
| cfg1_o | output | 8 | Configuration byte 1 |
| cfg4_o | output | 8 | Configuration byte 4 |
| pm_cap_o | output | 16 | Power-management capabilities |
| pm_csr_o | output | 8 | Power-management control/status |

## Verification
The bench uses three good images. The first loads after reset. The second is started by request and changes every mapped field, including the polarity of the flow-control bit and the ignored bits of the media byte, so that a swapped byte or a wrong inversion shows up. The third differs from the second only in the unmapped words, so any change at the outputs points to a decode that reacts to those words. A bad-signature image is tried twice. Loaded by request, it shows that earlier values survive. Loaded after reset, it shows that the reset defaults survive. A request issued in the middle of a pass tells whether a busy pass can be restarted.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  localparam int EE_AW = 6;
  localparam int EE_DW = 16;
  localparam int MAC_WORDS = 3;
  // word indices of mapped fields
  localparam int W_SVID  = 3;
  localparam int W_SSID  = 4;
  localparam int W_TMR   = 5;
  localparam int W_MED   = 6;
  localparam int W_MAC0  = 7;
  localparam int W_CFG01 = 10;
  localparam int W_PMC   = 11;
  localparam int W_PMCS  = 12;
  localparam logic [2:0] RD_HDR = 3'b110; // start bit + read opcode
endpackage

// File: rtl/eeld_skgen.sv
module eeld_skgen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          sk_q;
  logic          wrap;
  logic [CW-1:0] cnt_q;

  generate
    if (HALF > 1) begin : g_div
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
      assign wrap = (cnt_q == CW'(HALF - 1));
    end else begin : g_nodiv
      assign cnt_q = '0;
      assign wrap  = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sk_q <= 1'b0;
    else if (wrap) sk_q <= ~sk_q;
  end

  assign sk_o   = sk_q;
  assign rise_o = wrap & ~sk_q;
  assign fall_o = wrap & sk_q;

  AST_SK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o | fall_o) |=> (sk_o != $past(sk_o))) else $error("sk edge"); // R2
endmodule

// File: rtl/eeld_mw_rd.sv
module eeld_mw_rd
  import eeld_pkg::*;
#(
  parameter int AW = EE_AW,
  parameter int DW = EE_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sk_rise_i,
  input  logic          sk_fall_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          do_i,
  output logic          cs_o,
  output logic          di_o,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  localparam int HDR = 3 + AW;
  localparam int TOT = HDR + 1 + DW;
  localparam int KW  = $clog2(TOT);

  logic           pend_q, act_q, cs_q, di_q, vld_q;
  logic [HDR-1:0] hdr_q;
  logic [KW-1:0]  k_q;
  logic [DW-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cs_q   <= 1'b0;
      di_q   <= 1'b0;
      vld_q  <= 1'b0;
      hdr_q  <= '0;
      k_q    <= '0;
      rx_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (req_i && !pend_q && !act_q) begin
        pend_q <= 1'b1;
        hdr_q  <= {RD_HDR, addr_i};
      end
      if (sk_fall_i) begin
        if (pend_q) begin
          pend_q <= 1'b0;
          act_q  <= 1'b1;
          cs_q   <= 1'b1;
          k_q    <= '0;
          di_q   <= hdr_q[HDR-1];
          hdr_q  <= hdr_q << 1;
        end else if (act_q) begin
          if (k_q == KW'(TOT - 1)) begin
            act_q <= 1'b0;
            cs_q  <= 1'b0;
            di_q  <= 1'b0;
            vld_q <= 1'b1;
          end else begin
            k_q   <= k_q + 1'b1;
            di_q  <= hdr_q[HDR-1];
            hdr_q <= hdr_q << 1;
          end
        end
      end
      // dummy bit shifts through and falls off the top
      if (sk_rise_i && act_q && (k_q >= KW'(HDR)))
        rx_q <= {rx_q[DW-2:0], do_i};
    end
  end

  assign cs_o   = cs_q;
  assign di_o   = di_q;
  assign vld_o  = vld_q;
  assign data_o = rx_q;

  AST_DI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (di_o != $past(di_o)) |-> $past(sk_fall_i)) else $error("di timing"); // R2
  AST_REQ_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (!cs_o && !pend_q)) else $error("req while framing"); // R2
  AST_CS_END_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> vld_o) else $error("cs drop"); // R2
endmodule

// File: rtl/eeld_seq.sv
module eeld_seq
  import eeld_pkg::*;
#(
  parameter int          NUM_WORDS = 25,
  parameter logic [15:0] SIG       = 16'h8129
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic [EE_DW-1:0] data_i,
  output logic             rd_req_o,
  output logic [EE_AW-1:0] addr_o,
  output logic             we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sig_err_o
);
  localparam logic [EE_AW-1:0] LAST = EE_AW'(NUM_WORDS - 1);

  logic             boot_q, busy_q, done_q, err_q, req_q;
  logic [EE_AW-1:0] addr_q;
  logic             bad, last;

  assign last = (addr_q == LAST);
  assign bad  = (addr_q == '0) && (data_i != SIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      if (!busy_q) begin
        if (boot_q || start_i) begin
          boot_q <= 1'b0;
          busy_q <= 1'b1;
          err_q  <= 1'b0;
          addr_q <= '0;
          req_q  <= 1'b1;
        end
      end else if (vld_i) begin
        if (bad) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
          req_q  <= 1'b1;
        end
      end
    end
  end

  assign rd_req_o  = req_q;
  assign addr_o    = addr_q;
  assign we_o      = busy_q && vld_i && !bad && (addr_q != '0);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sig_err_o = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done width"); // R1
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done while busy"); // R1
  AST_ADDR_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST) else $error("addr range"); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (addr_q != $past(addr_q))) |-> (addr_q == $past(addr_q) + 1'b1))
    else $error("addr step"); // R3
  AST_ERR_WORD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_err_o) |-> (!busy_o && $past(addr_q) == '0)) else $error("err word"); // R4
endmodule

// File: rtl/eeld_regs.sv
module eeld_regs
  import eeld_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [EE_AW-1:0]       wa_i,
  input  logic [EE_DW-1:0]       wd_i,
  output logic [15:0]            sub_ven_o,
  output logic [15:0]            sub_id_o,
  output logic [7:0]             min_gnt_o,
  output logic [7:0]             max_lat_o,
  output logic [7:0]             media_o,
  output logic [15:0]            bmcr_o,
  output logic                   anar_pause_o,
  output logic [7:0]             cfg3_o,
  output logic [16*MAC_WORDS-1:0] mac_o,
  output logic [7:0]             cfg0_o,
  output logic [7:0]             cfg1_o,
  output logic [7:0]             cfg4_o,
  output logic [15:0]            pm_cap_o,
  output logic [7:0]             pm_csr_o
);
  logic [15:0] sv_q, sid_q, tmr_q, c01_q, pmc_q, pmcs_q;
  logic [7:0]  cfg3_q;
  logic [1:0]  med_q;
  logic [2:0]  bm_q;
  logic        pause_q;
  logic [16*MAC_WORDS-1:0] mac_q;
  logic [MAC_WORDS-1:0]    mac_hit;

  function automatic logic hit(input logic [EE_AW-1:0] a, input int n);
    return a == EE_AW'(n);
  endfunction

  generate
    for (genvar g = 0; g < MAC_WORDS; g++) begin : g_mac
      assign mac_hit[g] = we_i && hit(wa_i, W_MAC0 + g);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_q    <= '0;
      sid_q   <= '0;
      tmr_q   <= '0;
      c01_q   <= '0;
      pmc_q   <= '0;
      pmcs_q  <= '0;
      cfg3_q  <= '0;
      med_q   <= '0;
      bm_q    <= '0;
      pause_q <= 1'b1;
      mac_q   <= '0;
    end else begin
      if (we_i && hit(wa_i, W_SVID))  sv_q   <= wd_i;
      if (we_i && hit(wa_i, W_SSID))  sid_q  <= wd_i;
      if (we_i && hit(wa_i, W_TMR))   tmr_q  <= wd_i;
      if (we_i && hit(wa_i, W_CFG01)) c01_q  <= wd_i;
      if (we_i && hit(wa_i, W_PMC))   pmc_q  <= wd_i;
      if (we_i && hit(wa_i, W_PMCS))  pmcs_q <= wd_i;
      if (we_i && hit(wa_i, W_MED)) begin
        med_q   <= wd_i[7:6];
        bm_q    <= {wd_i[5], wd_i[4], wd_i[0]};
        pause_q <= ~wd_i[1];   // 0 in EEPROM = advertise pause
        cfg3_q  <= wd_i[15:8];
      end
      for (int g = 0; g < MAC_WORDS; g++)
        if (mac_hit[g]) mac_q[16*g +: 16] <= wd_i;
    end
  end

  assign sub_ven_o    = sv_q;
  assign sub_id_o     = sid_q;
  assign min_gnt_o    = tmr_q[7:0];
  assign max_lat_o    = tmr_q[15:8];
  assign media_o      = {med_q, 6'b0};
  assign bmcr_o       = {2'b00, bm_q[2], bm_q[1], 3'b000, bm_q[0], 8'h00};
  assign anar_pause_o = pause_q;
  assign cfg3_o       = cfg3_q;
  assign mac_o        = mac_q;
  assign cfg0_o       = c01_q[7:0];
  assign cfg1_o       = c01_q[15:8];
  assign pm_cap_o     = pmc_q;
  assign pm_csr_o     = pmcs_q[7:0];
  assign cfg4_o       = pmcs_q[15:8];

  AST_PAUSE_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && hit(wa_i, W_MED)) |-> (anar_pause_o == !$past(wd_i[1]))) else $error("pause"); // R9
  AST_MEDIA_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && hit(wa_i, W_MED)) |-> (media_o[7:6] == $past(wd_i[7:6]) && bmcr_o[8] == $past(wd_i[0])))
    else $error("media"); // R8
  AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wa_i < EE_AW'(W_SVID) || wa_i > EE_AW'(W_PMCS)))
      |=> ($stable(mac_o) && $stable(sub_ven_o) && $stable(pm_cap_o) && $stable(bmcr_o)))
    else $error("unmapped write"); // R12
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eeld_pkg::*;
#(
  parameter int          SK_HALF   = 2,
  parameter int          NUM_WORDS = 25,
  parameter logic [15:0] SIG_WORD  = 16'h8129,
  parameter logic [15:0] VEN_ID    = 16'h10EC,
  parameter logic [15:0] DEV_ID    = 16'h8139
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_req_i,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sig_err_o,
  output logic [15:0] ven_id_o,
  output logic [15:0] dev_id_o,
  output logic [15:0] sub_ven_o,
  output logic [15:0] sub_id_o,
  output logic [7:0]  min_gnt_o,
  output logic [7:0]  max_lat_o,
  output logic [7:0]  media_o,
  output logic [15:0] bmcr_o,
  output logic        anar_pause_o,
  output logic [7:0]  cfg3_o,
  output logic [47:0] mac_o,
  output logic [7:0]  cfg0_o,
  output logic [7:0]  cfg1_o,
  output logic [7:0]  cfg4_o,
  output logic [15:0] pm_cap_o,
  output logic [7:0]  pm_csr_o
);
  logic             sk_rise, sk_fall;
  logic             rd_req, rd_vld, we;
  logic [EE_AW-1:0] rd_addr;
  logic [EE_DW-1:0] rd_data;

  eeld_skgen #(.HALF(SK_HALF)) u_sk (
    .clk_i, .rst_ni, .sk_o(ee_sk_o), .rise_o(sk_rise), .fall_o(sk_fall)
  );

  eeld_mw_rd #(.AW(EE_AW), .DW(EE_DW)) u_rd (
    .clk_i, .rst_ni,
    .sk_rise_i(sk_rise), .sk_fall_i(sk_fall),
    .req_i(rd_req), .addr_i(rd_addr), .do_i(ee_do_i),
    .cs_o(ee_cs_o), .di_o(ee_di_o), .vld_o(rd_vld), .data_o(rd_data)
  );

  eeld_seq #(.NUM_WORDS(NUM_WORDS), .SIG(SIG_WORD)) u_seq (
    .clk_i, .rst_ni, .start_i(load_req_i),
    .vld_i(rd_vld), .data_i(rd_data),
    .rd_req_o(rd_req), .addr_o(rd_addr), .we_o(we),
    .busy_o, .done_o, .sig_err_o
  );

  eeld_regs u_regs (
    .clk_i, .rst_ni, .we_i(we), .wa_i(rd_addr), .wd_i(rd_data),
    .sub_ven_o, .sub_id_o, .min_gnt_o, .max_lat_o, .media_o, .bmcr_o,
    .anar_pause_o, .cfg3_o, .mac_o, .cfg0_o, .cfg1_o, .cfg4_o,
    .pm_cap_o, .pm_csr_o
  );

  assign ven_id_o = VEN_ID;
  assign dev_id_o = DEV_ID;

  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ee_cs_o) else $error("cs while idle"); // R2
  AST_SIGERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_err_o) |-> ($stable(mac_o) && $stable(sub_ven_o) && $stable(cfg3_o) && $stable(anar_pause_o)))
    else $error("regs moved on bad sig"); // R4
  AST_REQ_BUSY_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_req_i && !done_o) |=> $stable(rd_addr) || (rd_addr == $past(rd_addr) + 1'b1))
    else $error("restart while busy"); // R11
endmodule

// File: tb/tb_eeprom_autoload.sv
module tb_eeprom_autoload;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 1'b0;
  always #2 clk = ~clk;

  logic cs, sk, di, do_r;
  logic busy, done, sig_err, pause;
  logic [15:0] ven, dev, sven, sid, bmcr, pmcap;
  logic [7:0]  mgnt, mlat, media, cfg3, cfg0, cfg1, cfg4, pmcsr;
  logic [47:0] mac;

  eeprom_autoload dut (
    .clk_i(clk), .rst_ni(rst_n), .load_req_i(load_req),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_r),
    .busy_o(busy), .done_o(done), .sig_err_o(sig_err),
    .ven_id_o(ven), .dev_id_o(dev), .sub_ven_o(sven), .sub_id_o(sid),
    .min_gnt_o(mgnt), .max_lat_o(mlat), .media_o(media), .bmcr_o(bmcr),
    .anar_pause_o(pause), .cfg3_o(cfg3), .mac_o(mac), .cfg0_o(cfg0),
    .cfg1_o(cfg1), .cfg4_o(cfg4), .pm_cap_o(pmcap), .pm_csr_o(pmcsr)
  );

  int unsigned checks = 0, errs = 0, frames = 0;
  logic [15:0] mem [64];
  logic [5:0]  exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model and frame monitor
  int rcv = 0;
  logic [8:0] hdr = '0;
  initial do_r = 1'b0;
  always @(posedge cs) rcv = 0;
  always @(posedge sk) begin
    logic [5:0] e;
    if (cs) begin
      if (rcv < 9) hdr = {hdr[7:0], di};
      rcv++;
      if (rcv == 9) begin
        frames++;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected frame", 64'(hdr[5:0]), 64'h0);
        else begin
          e = exp_q.pop_front();
          chk(hdr[5:0] == e, "R3 word address order", 64'(hdr[5:0]), 64'(e));
          chk(hdr[8:6] == 3'b110, "R2 start bit and opcode", 64'(hdr[8:6]), 64'h6);
        end
      end
    end
  end
  always @(negedge sk)
    if (cs && rcv >= 9 && rcv <= 25)
      do_r = (rcv == 9) ? 1'b0 : mem[hdr[5:0]][25-rcv];

  task automatic push_pass(input bit full);
    for (int i = 0; i < (full ? 25 : 1); i++) exp_q.push_back(6'(i));
  endtask

  task automatic fill_img(input int s);
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357 + s * 16'h0F0F + i * i * s);
    mem[0] = 16'h8129;
  endtask

  task automatic pulse_req;
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 30000);
    chk(done == 1'b1, "R1 done pulse seen", 64'(done), 64'h1);
    chk(busy == 1'b0, "R1 busy low in done cycle", 64'(busy), 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R1 done lasts one clock", 64'(done), 64'h0);
  endtask

  task automatic check_regs;
    logic [7:0] b;
    b = mem[6][7:0];
    chk(ven == 16'h10EC && dev == 16'h8139, "R5 fixed ids", {32'h0, ven, dev}, 64'h10EC8139);
    chk(sven == mem[3], "R6 sub vendor", 64'(sven), 64'(mem[3]));
    chk(sid == mem[4], "R6 sub id", 64'(sid), 64'(mem[4]));
    chk({mlat, mgnt} == mem[5], "R7 timer bytes", 64'({mlat, mgnt}), 64'(mem[5]));
    chk(media == {b[7:6], 6'b0}, "R8 media bits", 64'(media), 64'({b[7:6], 6'b0}));
    chk(bmcr == {2'b0, b[5], b[4], 3'b0, b[0], 8'h0}, "R8 bmcr bits", 64'(bmcr),
        64'({2'b0, b[5], b[4], 3'b0, b[0], 8'h0}));
    chk(pause == ~b[1], "R9 inverted pause bit", 64'(pause), 64'(~b[1]));
    chk(cfg3 == mem[6][15:8], "R10 cfg3", 64'(cfg3), 64'(mem[6][15:8]));
    chk(mac == {mem[9], mem[8], mem[7]}, "R10 station address", 64'(mac), 64'({mem[9], mem[8], mem[7]}));
    chk({cfg1, cfg0} == mem[10], "R10 cfg0/cfg1", 64'({cfg1, cfg0}), 64'(mem[10]));
    chk(pmcap == mem[11], "R10 pm cap", 64'(pmcap), 64'(mem[11]));
    chk({cfg4, pmcsr} == mem[12], "R10 pm csr/cfg4", 64'({cfg4, pmcsr}), 64'(mem[12]));
  endtask

  task automatic check_defaults(input string tag);
    chk({sven, sid, mgnt, mlat, media, cfg3} == '0, tag, 64'({sven, sid, mgnt, mlat}), 64'h0);
    chk({bmcr, mac} == '0 && {cfg0, cfg1, cfg4, pmcap, pmcsr} == '0, tag, 64'(mac), 64'h0);
    chk(pause == 1'b1, tag, 64'(pause), 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int f0;
    // image 1: bit1 of media byte = 0, reserved bits set
    fill_img(1);
    mem[6][7:0] = 8'hAD;
    repeat (5) @(negedge clk);
    // R13 reset state
    chk({busy, done, sig_err, cs} == 4'b0, "R13 status low in reset", 64'({busy, done, sig_err, cs}), 64'h0);
    check_defaults("R13 reset defaults");
    chk(ven == 16'h10EC && dev == 16'h8139, "R5 fixed ids in reset", {32'h0, ven, dev}, 64'h10EC8139);
    push_pass(1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 boot pass busy", 64'(busy), 64'h1);
    wait_done;
    chk(frames == 25 && exp_q.size() == 0, "R3 boot reads 25 words", 64'(frames), 64'd25);
    chk(sig_err == 1'b0, "R4 good signature", 64'(sig_err), 64'h0);
    check_regs;

    // image 2: every mapped field changes, bit1 = 1
    fill_img(2);
    mem[6][7:0] = 8'h52;
    push_pass(1'b1);
    f0 = frames;
    pulse_req;
    @(negedge clk);
    chk(busy == 1'b1, "R11 request starts pass", 64'(busy), 64'h1);
    wait_done;
    chk(frames - f0 == 25, "R3 request pass length", 64'(frames - f0), 64'd25);
    check_regs;

    // image 3: only unmapped words differ (R12)
    mem[1] = ~mem[1];
    mem[2] = ~mem[2];
    for (int i = 13; i < 25; i++) mem[i] = ~mem[i];
    push_pass(1'b1);
    pulse_req;
    wait_done;
    check_regs;

    // bad signature on a request pass: old values survive (R4)
    mem[0] = 16'h8128;
    push_pass(1'b0);
    f0 = frames;
    pulse_req;
    wait_done;
    repeat (40) @(negedge clk);
    chk(sig_err == 1'b1, "R4 sig error flagged", 64'(sig_err), 64'h1);
    chk(frames - f0 == 1, "R4 only word 0 read", 64'(frames - f0), 64'd1);
    check_regs;

    // request while busy is ignored (R11), error clears (R4)
    mem[0] = 16'h8129;
    push_pass(1'b1);
    f0 = frames;
    pulse_req;
    repeat (3) @(negedge clk);
    chk(sig_err == 1'b0, "R4 error cleared at new pass", 64'(sig_err), 64'h0);
    repeat (300) @(negedge clk);
    pulse_req;
    wait_done;
    repeat (200) @(negedge clk);
    chk(busy == 1'b0, "R11 no restart from busy request", 64'(busy), 64'h0);
    chk(frames - f0 == 25 && exp_q.size() == 0, "R11 single pass", 64'(frames - f0), 64'd25);

    // reset with bad signature: defaults kept (R4)
    mem[0] = 16'h0000;
    push_pass(1'b0);
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_done;
    chk(sig_err == 1'b1, "R4 sig error after reset", 64'(sig_err), 64'h1);
    check_defaults("R4 defaults kept on bad signature");

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule